// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns a decoded addressing-mode code into a final operand address for a small CPU datapath. Each request carries the mode, the instruction's address field, the current program counter and three register values (base, index and pointer). Register-only modes finish in one cycle. Modes that must read a pointer word from memory use a single-request read port, which has a one-cycle latency.

Memory-indirect mode follows pointers through memory. Every fetched word carries a pointer flag in its top bit. While the flag is set, the low bits name the next word to fetch. The walk ends at the first word whose flag is clear. The number of reads in a walk is capped by a parameter, so a cyclic chain cannot hang the unit. Post-indexed mode fetches one pointer and then adds the index register to it. Update mode returns its computed address as a new value for the base register.

Each result reports the effective address, a one-cycle done strobe, an error flag, a base write-back value with its enable, and a count of the memory accesses that the instruction costs.

Top module: `ea_gen`

## Requirements
- R1: Mode 0 gives `pc + sext(field)`. Mode 1 gives `pc + 1 + sext(field)`. The 8-bit field is sign-extended to 16 bits and every sum wraps modulo 2^16. For example, pc 500 with field -50 gives 450 in mode 0 and 451 in mode 1.
- R2: Mode 2 gives `base_reg + index_reg`. Mode 3 gives `zext(field) + index_reg`. Both wrap modulo 2^16.
- R3: Mode 4 gives `ptr_reg` and mode 7 gives `pc + 1`. Neither mode issues a memory read.
- R4: Mode 5 first reads the word at `zext(field)`. Bit 16 of each word read is the pointer flag. While the flag is 1, bits 15:0 are the next read address. The result is bits 15:0 of the first word whose flag is 0.
- R5: Mode 6 reads one word at `zext(field)` and gives its bits 15:0 plus `index_reg`.
- R6: Mode 8 gives `base_reg + sext(field)`. It also raises `base_wb_en` together with `done`, with `base_wb` equal to that address. No other mode raises `base_wb_en`.
- R7: `acc_count` equals 2 plus the number of pointer reads made for the request. Register modes therefore report 2, and a single-level indirect operand reports 3.
- R8: A mode 5 walk makes at most MAX_HOPS reads (default 8). If the last permitted read still has its flag set, the unit raises `err` together with `done` and reports a count of MAX_HOPS+2. A walk that ends with exactly MAX_HOPS reads completes without error.
- R9: `start` is accepted only while `busy` is low, and a start while busy has no effect. `mem_req` is a one-cycle pulse. At most one read is outstanding, and `done` is raised only when the unit is idle.
- R10: Mode codes 9 to 15 complete on the cycle after start with `err` high, `ea` 0 and a count of 2.
- R11: After reset, `busy`, `done`, `err`, `mem_req` and `base_wb_en` are low and `ea` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| mode | input | 4 | Addressing-mode code |
| field | input | FW | Address field of the instruction |
| pc | input | AW | Address of the current instruction |
| base_reg | input | AW | Base register value |
| index_reg | input | AW | Index register value |
| ptr_reg | input | AW | Register holding a pointer for mode 4 |
| busy | output | 1 | A memory walk is in progress |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | AW | Read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | AW+1 | Read word: flag in the top bit, address below it |
| done | output | 1 | Result valid pulse |
| err | output | 1 | Chain cap exceeded or unknown mode; held until the next request |
| ea | output | AW | Effective address, held until the next result |
| base_wb_en | output | 1 | Base write-back enable, raised together with done |
| base_wb | output | AW | New base register value |
| acc_count | output | $clog2(MAX_HOPS+3) | Memory accesses the instruction costs |

## Verification
The embedded checks assume that `mem_valid` answers each `mem_req` exactly one cycle later and is never raised on its own. Under that assumption the request pulse can never repeat on consecutive cycles. The bench memory registers each request and returns the word on the next edge, so it never breaks that timing. The bench also drives `start` as a single-cycle pulse, sampled away from the clock edge. Its only start during a walk is the deliberate one in the busy test.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 16,
  parameter int FW = 8,
  parameter int MAX_HOPS = 8,
  localparam int CW = $clog2(MAX_HOPS + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [FW-1:0] field,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] base_reg,
  input  logic [AW-1:0] index_reg,
  input  logic [AW-1:0] ptr_reg,
  output logic          busy,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [AW:0]   mem_rdata,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] ea,
  output logic          base_wb_en,
  output logic [AW-1:0] base_wb,
  output logic [CW-1:0] acc_count
);
  localparam int HW = $clog2(MAX_HOPS + 1);
  localparam logic [3:0] M_PCREL   = 4'd0;
  localparam logic [3:0] M_PCNEXT  = 4'd1;
  localparam logic [3:0] M_BASEIDX = 4'd2;
  localparam logic [3:0] M_INDEXED = 4'd3;
  localparam logic [3:0] M_REGIND  = 4'd4;
  localparam logic [3:0] M_MEMIND  = 4'd5;
  localparam logic [3:0] M_POSTIDX = 4'd6;
  localparam logic [3:0] M_LITERAL = 4'd7;
  localparam logic [3:0] M_UPDATE  = 4'd8;

  typedef enum logic {S_IDLE, S_WAIT} st_t;
  st_t st;

  logic [3:0]    md_q;
  logic [AW-1:0] idx_q;
  logic [HW-1:0] hops;
  logic [AW-1:0] disp, fld_z, imm_ea;
  logic          imm_err;

  assign disp  = {{(AW-FW){field[FW-1]}}, field};
  assign fld_z = AW'(field);
  assign busy  = (st == S_WAIT);

  always_comb begin
    imm_ea  = '0;
    imm_err = 1'b0;
    case (mode)
      M_PCREL:   imm_ea = pc + disp;
      M_PCNEXT:  imm_ea = pc + AW'(1) + disp;
      M_BASEIDX: imm_ea = base_reg + index_reg;
      M_INDEXED: imm_ea = fld_z + index_reg;
      M_REGIND:  imm_ea = ptr_reg;
      M_LITERAL: imm_ea = pc + AW'(1);
      M_UPDATE:  imm_ea = base_reg + disp;
      default:   imm_err = 1'b1;
    endcase
  end

  logic          is_walk, flag, cap_hit;
  logic [AW-1:0] word;
  logic [CW-1:0] cnt_now;

  assign is_walk = (mode == M_MEMIND) || (mode == M_POSTIDX);
  assign flag    = mem_rdata[AW];
  assign word    = mem_rdata[AW-1:0];
  assign cap_hit = (hops == HW'(MAX_HOPS));
  assign cnt_now = CW'(hops) + CW'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      md_q       <= '0;
      idx_q      <= '0;
      hops       <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      ea         <= '0;
      base_wb_en <= 1'b0;
      base_wb    <= '0;
      acc_count  <= '0;
    end else begin
      done       <= 1'b0;
      base_wb_en <= 1'b0;
      mem_req    <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          md_q  <= mode;
          idx_q <= index_reg;
          if (is_walk) begin
            mem_req  <= 1'b1;
            mem_addr <= fld_z;
            hops     <= HW'(1);
            err      <= 1'b0;
            st       <= S_WAIT;
          end else begin
            ea         <= imm_ea;
            err        <= imm_err;
            done       <= 1'b1;
            acc_count  <= CW'(2);
            base_wb_en <= (mode == M_UPDATE);
            base_wb    <= imm_ea;
          end
        end
        S_WAIT: if (mem_valid) begin
          if (md_q == M_POSTIDX) begin
            ea        <= word + idx_q;
            done      <= 1'b1;
            acc_count <= cnt_now;
            st        <= S_IDLE;
          end else if (flag && !cap_hit) begin
            mem_req  <= 1'b1;
            mem_addr <= word;
            hops     <= hops + HW'(1);
          end else begin
            ea        <= word;
            err       <= flag;
            done      <= 1'b1;
            acc_count <= cnt_now;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R9
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R9
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy || done)); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done); // R8
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    base_wb_en |-> (done && base_wb == ea)); // R6
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (acc_count >= CW'(2) && acc_count <= CW'(MAX_HOPS + 2))); // R7
endmodule

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  field = '0;
  logic [15:0] pc = '0, base_reg = '0, index_reg = '0, ptr_reg = '0;
  logic        busy, mem_req, mem_valid, done, err, base_wb_en;
  logic [15:0] mem_addr, ea, base_wb;
  logic [16:0] mem_rdata;
  logic [3:0]  acc_count;

  ea_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
    .pc(pc), .base_reg(base_reg), .index_reg(index_reg), .ptr_reg(ptr_reg),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .done(done), .err(err),
    .ea(ea), .base_wb_en(base_wb_en), .base_wb(base_wb), .acc_count(acc_count)
  );

  logic [16:0] mem [0:255];
  int req_total = 0, b2b = 0, done_total = 0;
  logic prev_req = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_valid <= mem_req;
      mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  always @(posedge clk) begin
    if (mem_req) req_total <= req_total + 1;
    if (mem_req && prev_req) b2b <= b2b + 1;
    if (done) done_total <= done_total + 1;
    prev_req <= mem_req;
  end

  int tests = 0, fails = 0;
  logic [15:0] r_ea, r_wb;
  logic        r_err, r_wb_en;
  int          r_cnt, r_reads;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               tag, what, act, act, exp, exp);
    end
  endtask

  task automatic wait_done(input string tag);
    bit got = 0;
    for (int i = 0; i < 100; i++) begin
      if (done) begin
        got = 1;
        break;
      end
      @(negedge clk);
    end
    chk(got, tag, "done seen", int'(got), 1);
    r_ea    = ea;
    r_err   = err;
    r_wb_en = base_wb_en;
    r_wb    = base_wb;
    r_cnt   = int'(acc_count);
  endtask

  task automatic go(input logic [3:0] m, input logic [7:0] f, input logic [15:0] p,
                    input logic [15:0] b, input logic [15:0] x, input logic [15:0] r,
                    input string tag);
    int r0;
    @(negedge clk);
    r0 = req_total;
    mode = m; field = f; pc = p; base_reg = b; index_reg = x; ptr_reg = r;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(tag);
    r_reads = req_total - r0;
  endtask

  task automatic t_reset;
    chk(!busy && !done && !err && !mem_req && !base_wb_en, "R11", "control low",
        int'({busy, done, err, mem_req, base_wb_en}), 0);
    chk(ea == 16'h0, "R11", "ea", int'(ea), 0);
  endtask

  task automatic t_pcrel;
    go(4'd0, 8'hCE, 16'd500, 0, 0, 0, "R1");
    chk(r_ea == 16'd450, "R1", "pc-rel 500-50", int'(r_ea), 450);
    go(4'd1, 8'hCE, 16'd500, 0, 0, 0, "R1");
    chk(r_ea == 16'd451, "R1", "pc+1 rel", int'(r_ea), 451);
    go(4'd0, 8'h05, 16'hFFFF, 0, 0, 0, "R1");
    chk(r_ea == 16'h0004, "R1", "wrap", int'(r_ea), 4);
  endtask

  task automatic t_indexed;
    go(4'd2, 8'h00, 0, 16'h1000, 16'h0234, 0, "R2");
    chk(r_ea == 16'h1234, "R2", "base+index", int'(r_ea), 'h1234);
    chk(!r_wb_en, "R6", "no writeback for mode 2", int'(r_wb_en), 0);
    go(4'd3, 8'h10, 0, 0, 16'hFFF5, 0, "R2");
    chk(r_ea == 16'h0005, "R2", "field+index wrap", int'(r_ea), 5);
  endtask

  task automatic t_regind_literal;
    go(4'd4, 8'h00, 0, 0, 0, 16'hBEEF, "R3");
    chk(r_ea == 16'hBEEF, "R3", "register indirect", int'(r_ea), 'hBEEF);
    chk(r_reads == 0, "R3", "no reads", r_reads, 0);
    chk(r_cnt == 2, "R7", "count reg mode", r_cnt, 2);
    go(4'd7, 8'h00, 16'h0100, 0, 0, 0, "R3");
    chk(r_ea == 16'h0101, "R3", "literal", int'(r_ea), 'h101);
    chk(r_reads == 0, "R3", "literal no reads", r_reads, 0);
  endtask

  task automatic t_memind;
    go(4'd5, 8'h20, 0, 0, 0, 0, "R4");
    chk(r_ea == 16'h4321, "R4", "single level", int'(r_ea), 'h4321);
    chk(r_cnt == 3, "R7", "single level count", r_cnt, 3);
    chk(r_reads == 1, "R4", "single level reads", r_reads, 1);
    go(4'd5, 8'h30, 0, 0, 0, 0, "R4");
    chk(r_ea == 16'h7777, "R4", "three-level chain", int'(r_ea), 'h7777);
    chk(r_cnt == 5, "R7", "chain count", r_cnt, 5);
    chk(!r_err, "R4", "chain no err", int'(r_err), 0);
  endtask

  task automatic t_postidx;
    go(4'd6, 8'h50, 0, 0, 16'h0005, 0, "R5");
    chk(r_ea == 16'h2005, "R5", "post-indexed", int'(r_ea), 'h2005);
    chk(r_cnt == 3, "R7", "post-indexed count", r_cnt, 3);
  endtask

  task automatic t_update;
    go(4'd8, 8'hFC, 0, 16'h0300, 0, 0, "R6");
    chk(r_ea == 16'h02FC, "R6", "update ea", int'(r_ea), 'h2FC);
    chk(r_wb_en && r_wb == 16'h02FC, "R6", "writeback", int'(r_wb), 'h2FC);
  endtask

  task automatic t_cap;
    go(4'd5, 8'h70, 0, 0, 0, 0, "R8");
    chk(!r_err && r_ea == 16'h5555, "R8", "exact cap ok", int'(r_ea), 'h5555);
    chk(r_cnt == 10, "R8", "exact cap count", r_cnt, 10);
    go(4'd5, 8'h60, 0, 0, 0, 0, "R8");
    chk(r_err, "R8", "cyclic chain err", int'(r_err), 1);
    chk(r_reads == 8, "R8", "cyclic reads", r_reads, 8);
    chk(r_cnt == 10, "R8", "cyclic count", r_cnt, 10);
  endtask

  task automatic t_busy;
    int d0;
    @(negedge clk);
    mode = 4'd5; field = 8'h30; start = 1'b1;
    @(negedge clk);
    chk(busy, "R9", "busy during walk", int'(busy), 1);
    d0 = done_total;
    mode = 4'd2; base_reg = 16'h0001; index_reg = 16'h0001;
    @(negedge clk);
    start = 1'b0;
    wait_done("R9");
    chk(r_ea == 16'h7777, "R9", "start while busy ignored", int'(r_ea), 'h7777);
    repeat (6) @(negedge clk);
    chk(done_total - d0 == 1, "R9", "single done", done_total - d0, 1);
    chk(b2b == 0, "R9", "no back-to-back requests", b2b, 0);
  endtask

  task automatic t_badmode;
    go(4'd12, 8'h33, 16'h1234, 16'h1, 16'h1, 16'h1, "R10");
    chk(r_err && r_ea == 16'h0, "R10", "bad mode err/ea", int'(r_ea), 0);
    chk(r_cnt == 2, "R10", "bad mode count", r_cnt, 2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h20] = {1'b0, 16'h4321};
    mem[8'h30] = {1'b1, 16'h0031};
    mem[8'h31] = {1'b1, 16'h0040};
    mem[8'h40] = {1'b0, 16'h7777};
    mem[8'h50] = {1'b0, 16'h2000};
    mem[8'h60] = {1'b1, 16'h0060};
    for (int i = 0; i < 7; i++) mem[8'h70 + i] = {1'b1, 16'(8'h71 + i)};
    mem[8'h77] = {1'b0, 16'h5555};
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pcrel();
    t_indexed();
    t_regind_literal();
    t_memind();
    t_postidx();
    t_update();
    t_cap();
    t_busy();
    t_badmode();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule